// File: doc/BRIEF.md
# Soft-Start Half-Bridge On-Time Sequencer

This block is the digital soft-start engine of a half-bridge resonant controller. A start pulse loads a soft-start register with an initial on-time. The block then runs a repeating switching cycle in four phases: upper gate, dead time, lower gate, dead time. A single counter counts up from zero while the upper gate is on. It then counts back down to zero while the lower gate is on, so the two conduction intervals of one cycle are equal in length.

The upper interval ends when the counter reaches the soft-start value or when the regulation comparator trips, whichever happens first. On every Nth lower pulse the soft-start register grows by a programmable step and saturates at full scale. Each on-time therefore lasts longer than the one before, and the switching frequency falls. Because the ramp is paced by the switching cycles themselves, it slows down as the cycles get longer.

The soft-start value is driven out continuously so that it can address a reference DAC. Two sticky flags are also provided. One enables maximum-on-time fault detection once the ramp reaches a threshold. The other enables on-time repetition once the regulation loop starts to end upper pulses on its own.

Top module: `ssOnTimeSeq`

## Requirements
- R1: A synchronous reset clears the soft-start register and the counters and drives every output low. After reset the block stays idle, with both gates off, until `startPulse` is seen.
- R2: A start pulse in idle loads `initOnTime` into the soft-start register and begins an upper pulse in the next cycle. Without a trip, an upper pulse lasts max(S,1) clocks, where S is the soft-start value.
- R3: If `regTrip` is high during the k-th clock of an upper pulse and k is below the limit from R2, the upper pulse lasts exactly k clocks.
- R4: Each gate change, upper to lower and lower to upper, is separated by a dead interval of max(`deadCycles`,1) clocks in which both gates are low. The two gates are never high together.
- R5: Each lower pulse lasts exactly as many clocks as the upper pulse before it.
- R6: On the last clock of every Nth lower pulse the soft-start register grows by `incStep`, where N = max(`divRatio`,1). The new value applies to the next upper pulse.
- R7: The soft-start register saturates at 2^CNT_W-1 (255 by default) and never wraps.
- R8: While the sequencer runs, `faultEn` goes high one clock after the soft-start value equals `faultThresh`. It then stays high until an abort, a start or a reset.
- R9: `repeatEn` is low after a start. It is set when a trip ends an upper pulse before its limit, and then stays set. A trip that falls on the limit clock does not set it.
- R10: `abortReq` forces both gates low in the same cycle and returns the sequencer to idle. The soft-start value is kept, and both flags are cleared.
- R11: `ssLevel` always shows the current soft-start register value.
- R12: Without trips, the upper on-time never gets shorter from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | Starts the soft-start sequence from idle |
| abortReq | input | 1 | Forces both gates off and returns the sequencer to idle |
| regTrip | input | 1 | Regulation comparator trip; ends the upper pulse |
| initOnTime | input | CNT_W | Initial soft-start value, loaded at start |
| incStep | input | INC_W | Soft-start increment |
| divRatio | input | DIV_W | Number of lower pulses per increment (0 acts as 1) |
| deadCycles | input | DT_W | Dead interval in clocks (0 acts as 1) |
| faultThresh | input | CNT_W | Soft-start value that enables fault detection |
| gateHigh | output | 1 | Upper gate enable |
| gateLow | output | 1 | Lower gate enable |
| ssLevel | output | CNT_W | Soft-start value, drives the reference DAC |
| faultEn | output | 1 | Maximum-on-time fault detection enable |
| repeatEn | output | 1 | On-time repetition enable |

## Verification
In one clock, the regulation trip can coincide with the counter reaching the soft-start limit. The bench provokes this by raising `regTrip` on exactly the limit clock of an upper pulse. It then checks that the pulse still has its full length and that `repeatEn` stays low. A trip placed one pulse later, below the limit, must shorten the pulse and set the flag. The second collision is a ramp step that lands on saturation. The bench starts close to full scale with a step that overshoots, and expects the value to clamp at 255 on that step and hold there. It also expects `faultEn` to rise when the clamped value equals the threshold.

// File: rtl/ssSeqPkg.sv
package ssSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP,
    ST_DT1,
    ST_DOWN,
    ST_DT2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ssLoad;     // load soft-start register from initial value
    logic cntClr;     // clear on-time counter
    logic cntUp;      // on-time counter +1
    logic cntDown;    // on-time counter -1
    logic dtStart;    // begin a dead interval
    logic dtStep;     // advance dead interval counter
    logic pulseDone;  // last clock of a lower pulse
    logic divClr;     // clear lower-pulse divider
  } seqStrobe_t;

endpackage

// File: rtl/ssSeqDatapath.sv
module ssSeqDatapath
  import ssSeqPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int INC_W = 4,
  parameter int DIV_W = 3,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] initOnTime,
  input  logic [INC_W-1:0] incStep,
  input  logic [DIV_W-1:0] divRatio,
  input  logic [DT_W-1:0]  deadCycles,
  input  logic [CNT_W-1:0] faultThresh,
  output logic [CNT_W-1:0] ssLevel,
  output logic             upReach,
  output logic             downLast,
  output logic             dtDone,
  output logic             ssAtThresh
);

  localparam int SUM_W = CNT_W + 1;
  localparam int DVX_W = DIV_W + 1;

  logic [CNT_W-1:0] ssReg;
  logic [CNT_W-1:0] onCnt;
  logic [DIV_W-1:0] pulseCnt;
  logic [DT_W-1:0]  dtCnt;
  logic [SUM_W-1:0] ssSum;
  logic [DIV_W-1:0] divEff;
  logic             divHit;

  assign ssSum  = {1'b0, ssReg} + {{(SUM_W-INC_W){1'b0}}, incStep};
  assign divEff = (divRatio == '0) ? DIV_W'(1) : divRatio;
  assign divHit = ({1'b0, pulseCnt} + DVX_W'(1)) >= {1'b0, divEff};

  // soft-start register with saturation
  always_ff @(posedge clk) begin
    if (rst)
      ssReg <= '0;
    else if (strobe.ssLoad)
      ssReg <= initOnTime;
    else if (strobe.pulseDone && divHit)
      ssReg <= ssSum[CNT_W] ? {CNT_W{1'b1}} : ssSum[CNT_W-1:0];
  end

  // lower-pulse divider
  always_ff @(posedge clk) begin
    if (rst || strobe.divClr)
      pulseCnt <= '0;
    else if (strobe.pulseDone)
      pulseCnt <= divHit ? '0 : pulseCnt + DIV_W'(1);
  end

  // shared up/down on-time counter
  always_ff @(posedge clk) begin
    if (rst || strobe.cntClr)
      onCnt <= '0;
    else if (strobe.cntUp)
      onCnt <= onCnt + CNT_W'(1);
    else if (strobe.cntDown)
      onCnt <= onCnt - CNT_W'(1);
  end

  // dead interval counter
  always_ff @(posedge clk) begin
    if (rst)
      dtCnt <= '0;
    else if (strobe.dtStart)
      dtCnt <= DT_W'(1);
    else if (strobe.dtStep)
      dtCnt <= dtCnt + DT_W'(1);
  end

  assign upReach    = ({1'b0, onCnt} + SUM_W'(1)) >= {1'b0, ssReg};
  assign downLast   = onCnt <= CNT_W'(1);
  assign dtDone     = dtCnt >= deadCycles;
  assign ssAtThresh = ssReg == faultThresh;
  assign ssLevel    = ssReg;

endmodule

// File: rtl/ssSeqControl.sv
module ssSeqControl
  import ssSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startPulse,
  input  logic       abortReq,
  input  logic       regTrip,
  input  logic       upReach,
  input  logic       downLast,
  input  logic       dtDone,
  input  logic       ssAtThresh,
  output seqStrobe_t strobe,
  output logic       gateHigh,
  output logic       gateLow,
  output logic       faultEn,
  output logic       repeatEn
);

  seqState_t state, stateNext;
  logic      startNow;

  assign startNow = (state == ST_IDLE) && startPulse && !abortReq;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: if (startPulse) begin
        strobe.ssLoad = 1'b1;
        strobe.cntClr = 1'b1;
        strobe.divClr = 1'b1;
        stateNext     = ST_UP;
      end
      ST_UP: begin
        strobe.cntUp = 1'b1;
        if (upReach || regTrip) begin
          strobe.dtStart = 1'b1;
          stateNext      = ST_DT1;
        end
      end
      ST_DT1: begin
        if (dtDone) stateNext = ST_DOWN;
        else        strobe.dtStep = 1'b1;
      end
      ST_DOWN: begin
        strobe.cntDown = 1'b1;
        if (downLast) begin
          strobe.pulseDone = 1'b1;
          strobe.dtStart   = 1'b1;
          stateNext        = ST_DT2;
        end
      end
      ST_DT2: begin
        if (dtDone) stateNext = ST_UP;
        else        strobe.dtStep = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
    if (abortReq) begin
      strobe        = '0;
      strobe.cntClr = 1'b1;
      stateNext     = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_ff @(posedge clk) begin
    if (rst || abortReq || startNow) begin
      faultEn  <= 1'b0;
      repeatEn <= 1'b0;
    end else begin
      if (state != ST_IDLE && ssAtThresh)
        faultEn <= 1'b1;
      if (state == ST_UP && regTrip && !upReach)
        repeatEn <= 1'b1;
    end
  end

  assign gateHigh = (state == ST_UP)   && !abortReq;
  assign gateLow  = (state == ST_DOWN) && !abortReq;

endmodule

// File: rtl/ssOnTimeSeq.sv
module ssOnTimeSeq
  import ssSeqPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int INC_W = 4,
  parameter int DIV_W = 3,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startPulse,
  input  logic             abortReq,
  input  logic             regTrip,
  input  logic [CNT_W-1:0] initOnTime,
  input  logic [INC_W-1:0] incStep,
  input  logic [DIV_W-1:0] divRatio,
  input  logic [DT_W-1:0]  deadCycles,
  input  logic [CNT_W-1:0] faultThresh,
  output logic             gateHigh,
  output logic             gateLow,
  output logic [CNT_W-1:0] ssLevel,
  output logic             faultEn,
  output logic             repeatEn
);

  seqStrobe_t strobe;
  logic       upReach, downLast, dtDone, ssAtThresh;

  ssSeqControl ctrl (
    .clk        (clk),
    .rst        (rst),
    .startPulse (startPulse),
    .abortReq   (abortReq),
    .regTrip    (regTrip),
    .upReach    (upReach),
    .downLast   (downLast),
    .dtDone     (dtDone),
    .ssAtThresh (ssAtThresh),
    .strobe     (strobe),
    .gateHigh   (gateHigh),
    .gateLow    (gateLow),
    .faultEn    (faultEn),
    .repeatEn   (repeatEn)
  );

  ssSeqDatapath #(
    .CNT_W (CNT_W),
    .INC_W (INC_W),
    .DIV_W (DIV_W),
    .DT_W  (DT_W)
  ) dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .initOnTime  (initOnTime),
    .incStep     (incStep),
    .divRatio    (divRatio),
    .deadCycles  (deadCycles),
    .faultThresh (faultThresh),
    .ssLevel     (ssLevel),
    .upReach     (upReach),
    .downLast    (downLast),
    .dtDone      (dtDone),
    .ssAtThresh  (ssAtThresh)
  );

endmodule

// File: rtl/ssOnTimeSeqChk.sv
module ssOnTimeSeqChk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             startPulse,
  input logic             abortReq,
  input logic [CNT_W-1:0] faultThresh,
  input logic             gateHigh,
  input logic             gateLow,
  input logic [CNT_W-1:0] ssLevel,
  input logic             faultEn,
  input logic             repeatEn
);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(gateHigh && gateLow));

  p_high_to_low_gap_r4: assert property (@(posedge clk) disable iff (rst)
    gateHigh |=> !gateLow);

  p_low_to_high_gap_r4: assert property (@(posedge clk) disable iff (rst)
    gateLow |=> !gateHigh);

  p_abort_now_r10: assert property (@(posedge clk) disable iff (rst)
    abortReq |-> (!gateHigh && !gateLow));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
    abortReq |=> (!gateHigh && !gateLow && !faultEn && !repeatEn));

  p_ramp_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    gateLow |=> (ssLevel >= $past(ssLevel)));

  p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (faultEn && !abortReq && !startPulse) |=> faultEn);

  p_fault_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(faultEn) |-> $past(ssLevel == faultThresh));

  p_repeat_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (repeatEn && !abortReq && !startPulse) |=> repeatEn);

endmodule

bind ssOnTimeSeq ssOnTimeSeqChk #(.CNT_W(CNT_W)) chk (
  .clk         (clk),
  .rst         (rst),
  .startPulse  (startPulse),
  .abortReq    (abortReq),
  .faultThresh (faultThresh),
  .gateHigh    (gateHigh),
  .gateLow     (gateLow),
  .ssLevel     (ssLevel),
  .faultEn     (faultEn),
  .repeatEn    (repeatEn)
);

// File: tb/ssOnTimeSeq_test.sv
module ssOnTimeSeq_test;

  localparam int CNT_W = 8;
  localparam int SSMAX = (1 << CNT_W) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startPulse = 1'b0;
  logic       abortReq = 1'b0;
  logic       regTrip = 1'b0;
  logic [7:0] initOnTime = '0;
  logic [3:0] incStep = '0;
  logic [2:0] divRatio = '0;
  logic [3:0] deadCycles = '0;
  logic [7:0] faultThresh = '0;
  logic       gateHigh, gateLow, faultEn, repeatEn;
  logic [7:0] ssLevel;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ssOnTimeSeq uut (
    .clk(clk), .rst(rst), .startPulse(startPulse), .abortReq(abortReq),
    .regTrip(regTrip), .initOnTime(initOnTime), .incStep(incStep),
    .divRatio(divRatio), .deadCycles(deadCycles), .faultThresh(faultThresh),
    .gateHigh(gateHigh), .gateLow(gateLow), .ssLevel(ssLevel),
    .faultEn(faultEn), .repeatEn(repeatEn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finishRun();
  end

  // measures one switching cycle, starting at a negedge where gateHigh is high
  task automatic runCycle(input int tripAt, output int hi, output int dt1,
                          output int lo, output int dt2, output int overlap);
    int g = 0;
    hi = 0; dt1 = 0; lo = 0; dt2 = 0; overlap = 0;
    while (gateHigh && g < 2000) begin
      hi++;
      regTrip = (hi == tripAt);
      if (gateLow) overlap++;
      @(negedge clk); g++;
    end
    regTrip = 1'b0;
    while (!gateHigh && !gateLow && g < 2000) begin dt1++; @(negedge clk); g++; end
    while (gateLow && g < 2000) begin
      lo++;
      if (gateHigh) overlap++;
      @(negedge clk); g++;
    end
    while (!gateHigh && g < 2000) begin dt2++; @(negedge clk); g++; end
  endtask

  task automatic scenario(input int init, input int inc, input int dv,
                          input int dead, input int thr, input int nCyc,
                          input int tIdx1, input int tVal1,
                          input int tIdx2, input int tVal2);
    int ssExp = init;
    int pc = 0;
    bit seenF = 0;
    bit rep = 0;
    int prevHi = 0;
    int divE = (dv == 0) ? 1 : dv;
    int dtE  = (dead == 0) ? 1 : dead;
    int hi, dt1, lo, dt2, ov;
    @(negedge clk);
    initOnTime = 8'(init); incStep = 4'(inc); divRatio = 3'(dv);
    deadCycles = 4'(dead); faultThresh = 8'(thr);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(gateHigh == 1'b1, "R2", "upper gate on after start", int'(gateHigh), 1);
    check(repeatEn == 1'b0, "R9", "repeat flag low at start", int'(repeatEn), 0);
    for (int k = 0; k < nCyc; k++) begin
      int lim = (ssExp == 0) ? 1 : ssExp;
      int t = (k == tIdx1) ? tVal1 : ((k == tIdx2) ? tVal2 : 0);
      int expHi = (t > 0 && t < lim) ? t : lim;
      check(int'(ssLevel) == ssExp, (ssExp == SSMAX) ? "R7" : "R11",
            "soft-start level", int'(ssLevel), ssExp);
      runCycle(t, hi, dt1, lo, dt2, ov);
      check(hi == expHi, (t > 0) ? "R3" : "R2", "upper width", hi, expHi);
      check(lo == hi, "R5", "lower width", lo, hi);
      check(dt1 == dtE, "R4", "dead after upper", dt1, dtE);
      check(dt2 == dtE, "R4", "dead after lower", dt2, dtE);
      check(ov == 0, "R4", "gate overlap", ov, 0);
      if (t == 0 && k > 0) check(hi >= prevHi, "R12", "monotone on-time", hi, prevHi);
      if (t == 0) prevHi = hi;
      if (t > 0 && t < lim) rep = 1;
      if (ssExp == thr) seenF = 1;
      pc++;
      if (pc >= divE) begin
        ssExp = (ssExp + inc > SSMAX) ? SSMAX : ssExp + inc;
        pc = 0;
      end
      if (ssExp == thr) seenF = 1;
      check(faultEn == seenF, "R8", "fault enable", int'(faultEn), int'(seenF));
      check(repeatEn == rep, "R9", "repeat enable", int'(repeatEn), int'(rep));
      check(int'(ssLevel) == ssExp, (ssExp == SSMAX) ? "R7" : "R6",
            "level after step", int'(ssLevel), ssExp);
    end
    // abort while upper gate is on
    abortReq = 1'b1;
    #1;
    check(!gateHigh && !gateLow, "R10", "gates off same cycle",
          int'(gateHigh) + int'(gateLow), 0);
    @(negedge clk);
    abortReq = 1'b0;
    check(!faultEn && !repeatEn, "R10", "flags cleared by abort",
          int'(faultEn) + int'(repeatEn), 0);
    check(int'(ssLevel) == ssExp, "R10", "level kept after abort", int'(ssLevel), ssExp);
    repeat (3) @(negedge clk);
    check(!gateHigh && !gateLow, "R10", "idle after abort",
          int'(gateHigh) + int'(gateLow), 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!gateHigh && !gateLow, "R1", "gates low in reset", int'(gateHigh) + int'(gateLow), 0);
    check(ssLevel == 8'd0, "R1", "level zero in reset", int'(ssLevel), 0);
    check(!faultEn && !repeatEn, "R1", "flags low in reset", int'(faultEn) + int'(repeatEn), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(!gateHigh && !gateLow, "R1", "idle without start", int'(gateHigh) + int'(gateLow), 0);

    // basic ramp, threshold hit on the way
    scenario(5, 3, 1, 2, 20, 8, -1, 0, -1, 0);
    // zero initial value, divided increment, zero dead setting
    scenario(0, 1, 3, 0, 255, 9, -1, 0, -1, 0);
    // saturation collides with a step; threshold at full scale
    scenario(250, 7, 1, 1, 255, 4, -1, 0, -1, 0);
    // trip on the limit clock, then a trip below the limit
    scenario(10, 2, 1, 3, 200, 4, 0, 10, 1, 4);

    // reset in the middle of a run
    @(negedge clk);
    initOnTime = 8'd40; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(ssLevel == 8'd0 && !gateHigh && !gateLow, "R1", "reset mid-run",
          int'(ssLevel) + int'(gateHigh), 0);
    finishRun();
  end

endmodule